// File: doc/BRIEF.md
# Host Interrupt and FIFO Register Bank

This block is the host-facing register bank of a USB Type-C / Power Delivery port controller. Event pulses from the rest of the controller are latched into a flag register. A host read of that register returns the latched set and clears it. Each flag has its own enable-suppress bit in a mask register, and a global mask bit in the control register silences the whole interrupt. The combined result drives an active-low interrupt line.

The same bank gives the host a single data port. A write there queues a byte for the transmit serializer, and a read takes the oldest byte the receiver has delivered. Three command bits in the control register clear themselves: start transmission, purge the transmit queue, and reset the whole bank. A status register reports empty and full for both queues, plus a sticky flag for a dropped transmit byte.

The host interface is a strobe bus. A load pulse sets an address pointer, and every read or write then steps the pointer by one. At the data port the pointer stays fixed, so a burst streams bytes through the queues.

Top module: `hc_regbank`

## Requirements
- R1: Each set bit of `evt_in` sets the matching bit of the flag register (address 0x02). A host read of 0x02 returns the flags held before the read and clears them. An event arriving in the same cycle as that read stays set afterwards.
- R2: `irq_n` is low exactly when some flag bit is set whose bit in the mask register (0x01, 1 = suppress) is 0, and the global mask (control register 0x00 bit 5) is 0.
- R3: A write to address 0x43 appends the byte to the transmit queue, and the serializer sees the oldest byte on `tx_byte` while `tx_avail` is high. A write while the queue is full is dropped and sets the sticky overflow bit (status bit 0).
- R4: A read of 0x43 returns the oldest received byte and removes it. A read of an empty receive queue returns 0x00 and leaves the queue empty.
- R5: `host_addr_ld` loads the pointer, and the access in that same cycle already uses the loaded address. Each access then advances the pointer by one, except an access at 0x43, after which the pointer stays at 0x43.
- R6: The status register 0x03 has bit 5 receive-empty, bit 4 receive-full, bit 3 transmit-empty, bit 2 transmit-full and bit 0 overflow. It reads 0x28 after reset.
- R7: Writing 1 to control bit 0 raises `tx_start` for exactly the cycle after the write. The bit reads back 0.
- R8: Writing 1 to control bit 1 empties the transmit queue and clears the overflow bit, and the bit reads back 0. A transmit push and a `tx_pop` in the same cycle both take effect.
- R9: Writing 1 to control bit 2 returns the masks, flags, overflow bit, read data and both queues to their reset state. It suppresses any `tx_start` requested in the same write.
- R10: Read data appears on `host_rdata` in the cycle after the read strobe and holds until the next read. Addresses with no register read 0x00.
- R11: An `rx_push` while the receive queue is full is dropped. Bytes already queued keep their order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr_ld | input | 1 | Load the address pointer from host_addr |
| host_addr | input | 8 | Address to load |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data |
| evt_in | input | N_EVT | Event pulses, one per source |
| irq_n | output | 1 | Active-low interrupt |
| tx_start | output | 1 | One-cycle transmit start pulse |
| tx_pop | input | 1 | Serializer takes the head transmit byte |
| tx_avail | output | 1 | Transmit queue holds data |
| tx_byte | output | 8 | Head of the transmit queue |
| rx_push | input | 1 | Receiver delivers a byte |
| rx_byte | input | 8 | Received byte |

## Verification
Two pairs of actions can fall in the same clock cycle. An event pulse can land in the cycle the host reads and clears the flag register. A queue can be pushed from one side while the other side pops it. The bench provokes both pairs directly: it pulses `evt_in` together with a flag read, drives a data-port write together with `tx_pop`, and drives `rx_push` together with a data-port read. A long mixed run then makes them collide at random. Each outcome is judged against a behavioural model built on queues, which expects the fresh event to survive the clear and both queue operations to take effect in order.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
    localparam int DW = 8;
    localparam int AW = 8;

    typedef logic [DW-1:0] byte_t;
    typedef logic [AW-1:0] addr_t;

    localparam addr_t A_CTRL = 8'h00;
    localparam addr_t A_MASK = 8'h01;
    localparam addr_t A_FLAG = 8'h02;
    localparam addr_t A_STAT = 8'h03;
    localparam addr_t A_FIFO = 8'h43;

    localparam int CB_GO    = 0;
    localparam int CB_PURGE = 1;
    localparam int CB_SRST  = 2;
    localparam int CB_GMASK = 5;
endpackage

// File: rtl/rb_sync_fifo.sv
module rb_sync_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           wp;
        logic [PW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } fifo_st_t;

    fifo_st_t st_q, st_d;
    logic do_push, do_pop;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CW'(DEPTH));
    assign head  = st_q.mem[st_q.rp];

    always_comb begin
        st_d    = st_q;
        do_push = push && !full;
        do_pop  = pop && !empty;
        if (do_push) begin
            st_d.mem[st_q.wp] = push_data;
            st_d.wp = nxt(st_q.wp);
        end
        if (do_pop) begin
            st_d.rp = nxt(st_q.rp);
        end
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + CW'(1);
            2'b01:   st_d.cnt = st_q.cnt - CW'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
        if (flush) begin
            st_d.wp  = '0;
            st_d.rp  = '0;
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/rb_evt_latch.sv
module rb_evt_latch #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_all,
    input  logic         rd_clr,
    input  logic [N-1:0] evt,
    output logic [N-1:0] flags
);
    typedef struct packed {
        logic [N-1:0] flg;
    } evt_st_t;

    evt_st_t st_q, st_d;

    assign flags = st_q.flg;

    always_comb begin
        st_d = st_q;
        if (rd_clr) begin
            st_d.flg = '0;
        end
        // a pulse in the clearing cycle is merged after the clear
        st_d.flg = st_d.flg | evt;
        if (clr_all) begin
            st_d.flg = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/rb_addr_ptr.sv
module rb_addr_ptr
    import regbank_pkg::*;
#(
    parameter addr_t HOLD_ADDR = A_FIFO
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  ld,
    input  addr_t ld_addr,
    input  logic  access,
    output addr_t eff_addr,
    output addr_t ptr
);
    typedef struct packed {
        addr_t p;
    } ptr_st_t;

    ptr_st_t st_q, st_d;

    assign eff_addr = ld ? ld_addr : st_q.p;
    assign ptr      = st_q.p;

    always_comb begin
        st_d   = st_q;
        st_d.p = eff_addr;
        if (access && (eff_addr != HOLD_ADDR)) begin
            st_d.p = eff_addr + addr_t'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/hc_regbank.sv
module hc_regbank
    import regbank_pkg::*;
#(
    parameter int N_EVT    = 8,
    parameter int TX_DEPTH = 8,
    parameter int RX_DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_addr_ld,
    input  logic [AW-1:0]    host_addr,
    input  logic             host_wr,
    input  logic             host_rd,
    input  logic [DW-1:0]    host_wdata,
    output logic [DW-1:0]    host_rdata,
    input  logic [N_EVT-1:0] evt_in,
    output logic             irq_n,
    output logic             tx_start,
    input  logic             tx_pop,
    output logic             tx_avail,
    output logic [DW-1:0]    tx_byte,
    input  logic             rx_push,
    input  logic [DW-1:0]    rx_byte
);
    typedef struct packed {
        logic             glb;
        logic [N_EVT-1:0] mask;
        logic             ovf;
        byte_t            rdata;
        logic             go;
    } top_st_t;

    localparam top_st_t ST_RST = '{glb: 1'b0, mask: '0, ovf: 1'b0,
                                   rdata: '0, go: 1'b0};

    top_st_t st_q, st_d;

    addr_t            eff_addr, ptr_q;
    logic             access;
    logic             wr_ctrl, soft_rst, purge;
    logic             tx_push, rx_pop, flag_rd;
    logic [N_EVT-1:0] flags;
    logic             tx_empty, tx_full, rx_empty, rx_full;
    byte_t            rx_head, stat_val, rd_val;
    logic             ovf_q, glb_mask;

    assign access = host_wr | host_rd;

    rb_addr_ptr #(.HOLD_ADDR(A_FIFO)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld       (host_addr_ld),
        .ld_addr  (host_addr),
        .access   (access),
        .eff_addr (eff_addr),
        .ptr      (ptr_q)
    );

    always_comb begin
        wr_ctrl  = host_wr && (eff_addr == A_CTRL);
        soft_rst = wr_ctrl && host_wdata[CB_SRST];
        purge    = (wr_ctrl && host_wdata[CB_PURGE]) || soft_rst;
        tx_push  = host_wr && (eff_addr == A_FIFO);
        rx_pop   = host_rd && (eff_addr == A_FIFO) && !soft_rst;
        flag_rd  = host_rd && (eff_addr == A_FLAG);
    end

    rb_evt_latch #(.N(N_EVT)) u_evt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_all (soft_rst),
        .rd_clr  (flag_rd),
        .evt     (evt_in),
        .flags   (flags)
    );

    rb_sync_fifo #(.W(DW), .DEPTH(TX_DEPTH)) u_txq (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (purge),
        .push      (tx_push),
        .push_data (host_wdata),
        .pop       (tx_pop),
        .head      (tx_byte),
        .empty     (tx_empty),
        .full      (tx_full)
    );

    rb_sync_fifo #(.W(DW), .DEPTH(RX_DEPTH)) u_rxq (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (soft_rst),
        .push      (rx_push),
        .push_data (rx_byte),
        .pop       (rx_pop),
        .head      (rx_head),
        .empty     (rx_empty),
        .full      (rx_full)
    );

    always_comb begin
        stat_val = {2'b00, rx_empty, rx_full, tx_empty, tx_full, 1'b0, st_q.ovf};
        case (eff_addr)
            A_CTRL:  rd_val = byte_t'({st_q.glb, 5'b00000});
            A_MASK:  rd_val = byte_t'(st_q.mask);
            A_FLAG:  rd_val = byte_t'(flags);
            A_STAT:  rd_val = stat_val;
            A_FIFO:  rd_val = rx_empty ? '0 : rx_head;
            default: rd_val = '0;
        endcase
    end

    always_comb begin
        st_d    = st_q;
        st_d.go = 1'b0;
        if (host_rd) begin
            st_d.rdata = rd_val;
        end
        if (host_wr && (eff_addr == A_MASK)) begin
            st_d.mask = host_wdata[N_EVT-1:0];
        end
        if (wr_ctrl) begin
            st_d.glb = host_wdata[CB_GMASK];
            st_d.go  = host_wdata[CB_GO];
        end
        if (tx_push && tx_full) begin
            st_d.ovf = 1'b1;
        end
        if (purge) begin
            st_d.ovf = 1'b0;
        end
        if (soft_rst) begin
            st_d = ST_RST;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign ovf_q      = st_q.ovf;
    assign glb_mask   = st_q.glb;
    assign host_rdata = st_q.rdata;
    assign tx_start   = st_q.go;
    assign tx_avail   = !tx_empty;
    assign irq_n      = !((|(flags & ~st_q.mask)) && !st_q.glb);
endmodule

// File: rtl/rb_checker.sv
module rb_checker
    import regbank_pkg::*;
#(
    parameter int    N_EVT     = 8,
    parameter addr_t FIFO_ADDR = A_FIFO
) (
    input logic             clk,
    input logic             rst_n,
    input logic             host_wr,
    input logic             host_rd,
    input logic [DW-1:0]    host_rdata,
    input logic [N_EVT-1:0] evt_in,
    input logic             irq_n,
    input logic             tx_start,
    input addr_t            eff_addr,
    input addr_t            ptr_q,
    input logic [N_EVT-1:0] flags,
    input logic             ovf_q,
    input logic             glb_mask,
    input logic             tx_full,
    input logic             tx_empty,
    input logic             rx_empty,
    input logic             soft_rst,
    input logic             purge
);
    AST_EVT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_in != '0 && !soft_rst) |=> ((flags & $past(evt_in)) == $past(evt_in))); // R1

    AST_GMASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        glb_mask |-> irq_n); // R2

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && eff_addr == FIFO_ADDR && tx_full) |=> ovf_q); // R3

    AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && eff_addr == FIFO_ADDR && rx_empty) |=> (host_rdata == '0)); // R4

    AST_PORT_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((host_rd || host_wr) && eff_addr == FIFO_ADDR) |=> (ptr_q == FIFO_ADDR)); // R5

    AST_START_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> $past(host_wr)); // R7

    AST_PURGE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        purge |=> tx_empty); // R8

    AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (flags == '0 && rx_empty && !tx_start && !ovf_q)); // R9
endmodule

bind hc_regbank rb_checker #(.N_EVT(N_EVT), .FIFO_ADDR(A_FIFO)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_rdata (host_rdata),
    .evt_in     (evt_in),
    .irq_n      (irq_n),
    .tx_start   (tx_start),
    .eff_addr   (eff_addr),
    .ptr_q      (ptr_q),
    .flags      (flags),
    .ovf_q      (ovf_q),
    .glb_mask   (glb_mask),
    .tx_full    (tx_full),
    .tx_empty   (tx_empty),
    .rx_empty   (rx_empty),
    .soft_rst   (soft_rst),
    .purge      (purge)
);

// File: tb/sim_hc_regbank.sv
`timescale 1ns/1ps
module sim_hc_regbank;
    localparam int TXD = 4;
    localparam int RXD = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_addr_ld = 1'b0;
    logic [7:0] host_addr = '0;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic [7:0] evt_in = '0;
    logic       irq_n;
    logic       tx_start;
    logic       tx_pop = 1'b0;
    logic       tx_avail;
    logic [7:0] tx_byte;
    logic       rx_push = 1'b0;
    logic [7:0] rx_byte = '0;

    hc_regbank #(.N_EVT(8), .TX_DEPTH(TXD), .RX_DEPTH(RXD)) u0 (
        .clk(clk), .rst_n(rst_n), .host_addr_ld(host_addr_ld), .host_addr(host_addr),
        .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .evt_in(evt_in), .irq_n(irq_n), .tx_start(tx_start),
        .tx_pop(tx_pop), .tx_avail(tx_avail), .tx_byte(tx_byte),
        .rx_push(rx_push), .rx_byte(rx_byte)
    );

    always #2.5 clk = ~clk;

    int total = 0;
    int bad = 0;

    // behavioural reference
    logic [7:0] m_mask, m_flags, m_rdata, m_ptr;
    bit         m_glb, m_ovf, m_go;
    byte        txq[$];
    byte        rxq[$];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_mask = 0; m_flags = 0; m_rdata = 0; m_glb = 0; m_ovf = 0; m_go = 0;
        txq.delete(); rxq.delete();
    endtask

    task automatic model_step();
        logic [7:0] eff, stat, nfl;
        bit txfull;
        int rxsz;
        if (!rst_n) begin
            model_reset();
            m_ptr = 0;
            return;
        end
        eff    = host_addr_ld ? host_addr : m_ptr;
        txfull = (txq.size() >= TXD);
        rxsz   = rxq.size();
        stat   = {2'b00, rxq.size() == 0, rxq.size() == RXD, txq.size() == 0, txfull, 1'b0, m_ovf};
        m_go   = 0;
        if (host_wr && eff == 8'h00 && host_wdata[2]) begin
            model_reset();
        end else begin
            nfl = m_flags;
            if (host_rd) begin
                case (eff)
                    8'h00: m_rdata = {2'b00, m_glb, 5'b00000};
                    8'h01: m_rdata = m_mask;
                    8'h02: begin m_rdata = m_flags; nfl = 0; end
                    8'h03: m_rdata = stat;
                    8'h43: m_rdata = (rxq.size() == 0) ? 8'h00 : rxq.pop_front();
                    default: m_rdata = 8'h00;
                endcase
            end
            if (rx_push && rxsz < RXD) rxq.push_back(rx_byte);
            m_flags = nfl | evt_in;
            if (tx_pop && txq.size() > 0) void'(txq.pop_front());
            if (host_wr && eff == 8'h43) begin
                if (txfull) m_ovf = 1;
                else txq.push_back(host_wdata);
            end
            if (host_wr && eff == 8'h00) begin
                m_glb = host_wdata[5];
                m_go  = host_wdata[0];
                if (host_wdata[1]) begin
                    txq.delete();
                    m_ovf = 0;
                end
            end
            if (host_wr && eff == 8'h01) m_mask = host_wdata;
        end
        if (host_wr || host_rd) m_ptr = (eff == 8'h43) ? eff : eff + 8'd1;
        else m_ptr = eff;
    endtask

    task automatic compare_all();
        bit exp_irq;
        exp_irq = !((|(m_flags & ~m_mask)) && !m_glb);
        chk(host_rdata == m_rdata, "R10 rdata", host_rdata, m_rdata);
        chk(irq_n == exp_irq, "R2 irq_n", irq_n, exp_irq);
        chk(tx_start == m_go, "R7 tx_start", tx_start, m_go);
        chk(tx_avail == (txq.size() != 0), "R8 tx_avail", tx_avail, txq.size() != 0);
        if (txq.size() != 0) chk(tx_byte == txq[0], "R3 tx_byte", tx_byte, txq[0]);
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
        host_addr_ld = 0; host_wr = 0; host_rd = 0;
        evt_in = 0; tx_pop = 0; rx_push = 0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        host_addr_ld = 1; host_addr = a; host_wr = 1; host_wdata = d; tick();
    endtask
    task automatic wr_next(input logic [7:0] d);
        host_wr = 1; host_wdata = d; tick();
    endtask
    task automatic rd(input logic [7:0] a);
        host_addr_ld = 1; host_addr = a; host_rd = 1; tick();
    endtask
    task automatic rd_next();
        host_rd = 1; tick();
    endtask

    initial begin
        #(5ns * 150000);
        total++; bad++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        model_reset();
        m_ptr = 0;
        repeat (3) tick();
        rst_n = 1;
        tick();
        chk(irq_n == 1'b1, "R2 reset irq_n", irq_n, 1);
        rd(8'h03);
        chk(host_rdata == 8'h28, "R6 reset status", host_rdata, 8'h28);

        // masking
        wr(8'h01, 8'h0F);
        evt_in = 8'h05; tick();
        chk(irq_n == 1'b1, "R2 masked event", irq_n, 1);
        evt_in = 8'h10; tick();
        chk(irq_n == 1'b0, "R2 unmasked event", irq_n, 0);
        wr(8'h00, 8'h20);
        chk(irq_n == 1'b1, "R2 global mask", irq_n, 1);
        wr(8'h00, 8'h00);
        chk(irq_n == 1'b0, "R2 global unmask", irq_n, 0);

        // read-to-clear with coincident event
        evt_in = 8'h80; rd(8'h02);
        chk(host_rdata == 8'h15, "R1 first read", host_rdata, 8'h15);
        rd(8'h02);
        chk(host_rdata == 8'h80, "R1 coincident event kept", host_rdata, 8'h80);
        rd(8'h02);
        chk(host_rdata == 8'h00, "R1 cleared", host_rdata, 0);
        chk(irq_n == 1'b1, "R2 idle after clear", irq_n, 1);

        // address auto-increment
        rd(8'h00); rd_next();
        chk(host_rdata == 8'h0F, "R5 increment to mask", host_rdata, 8'h0F);
        rd_next(); rd_next();
        chk(host_rdata == 8'h28, "R5 increment to status", host_rdata, 8'h28);

        // transmit queue fill and overflow
        wr(8'h43, 8'hA1); wr_next(8'hA2); wr_next(8'hA3); wr_next(8'hA4); wr_next(8'hA5);
        chk(tx_byte == 8'hA1, "R3 head byte", tx_byte, 8'hA1);
        rd(8'h03);
        chk(host_rdata == 8'h25, "R3 full with overflow", host_rdata, 8'h25);
        tx_pop = 1; tick();
        tx_pop = 1; wr(8'h43, 8'hB6);
        chk(tx_byte == 8'hA3, "R8 push with pop", tx_byte, 8'hA3);
        rd(8'h03);
        chk(host_rdata == 8'h21, "R3 sticky overflow", host_rdata, 8'h21);
        wr(8'h00, 8'h02);
        chk(tx_avail == 1'b0, "R8 purge empties", tx_avail, 0);
        rd(8'h03);
        chk(host_rdata == 8'h28, "R8 purge clears overflow", host_rdata, 8'h28);
        rd(8'h00);
        chk(host_rdata == 8'h00, "R8 purge bit reads 0", host_rdata, 0);

        // start pulse
        wr(8'h00, 8'h01);
        chk(tx_start == 1'b1, "R7 pulse", tx_start, 1);
        tick();
        chk(tx_start == 1'b0, "R7 pulse ends", tx_start, 0);
        rd(8'h00);
        chk(host_rdata == 8'h00, "R7 start bit reads 0", host_rdata, 0);

        // receive queue
        for (int i = 1; i <= 5; i++) begin
            rx_push = 1; rx_byte = 8'(i * 8'h11); tick();
        end
        rd(8'h03);
        chk(host_rdata == 8'h18, "R11 receive full", host_rdata, 8'h18);
        rd(8'h43);
        chk(host_rdata == 8'h11, "R4 first byte", host_rdata, 8'h11);
        rx_push = 1; rx_byte = 8'h66; rd_next();
        chk(host_rdata == 8'h22, "R4 pop with push", host_rdata, 8'h22);
        rd_next();
        chk(host_rdata == 8'h33, "R4 third", host_rdata, 8'h33);
        tick();
        chk(host_rdata == 8'h33, "R10 hold", host_rdata, 8'h33);
        rd_next(); rd_next();
        chk(host_rdata == 8'h66, "R11 order kept", host_rdata, 8'h66);
        rd_next();
        chk(host_rdata == 8'h00, "R4 empty read", host_rdata, 0);
        rd_next();
        chk(host_rdata == 8'h00, "R4 empty again", host_rdata, 0);
        rd(8'h10);
        chk(host_rdata == 8'h00, "R10 unmapped", host_rdata, 0);

        // soft reset
        wr(8'h01, 8'hF0);
        evt_in = 8'hF0; tick();
        wr(8'h43, 8'h77);
        rx_push = 1; rx_byte = 8'h99; tick();
        wr(8'h00, 8'h05);
        chk(tx_start == 1'b0, "R9 start suppressed", tx_start, 0);
        chk(tx_avail == 1'b0, "R9 tx cleared", tx_avail, 0);
        rd(8'h01);
        chk(host_rdata == 8'h00, "R9 mask cleared", host_rdata, 0);
        rd(8'h02);
        chk(host_rdata == 8'h00, "R9 flags cleared", host_rdata, 0);
        rd(8'h03);
        chk(host_rdata == 8'h28, "R9 status reset", host_rdata, 8'h28);

        // mixed traffic against the model
        for (int n = 0; n < 3000; n++) begin
            int op;
            logic [7:0] pick;
            op = $urandom_range(0, 5);
            case (op)
                0: pick = 8'h00;
                1: pick = 8'h01;
                2: pick = 8'h02;
                3: pick = 8'h03;
                4: pick = 8'h43;
                default: pick = 8'h10;
            endcase
            host_addr_ld = ($urandom_range(0, 2) == 0);
            host_addr = pick;
            case ($urandom_range(0, 3))
                0: host_wr = 1;
                1: host_rd = 1;
                default: ;
            endcase
            host_wdata = 8'($urandom);
            if ($urandom_range(0, 15) != 0) host_wdata[2] = 1'b0;
            if ($urandom_range(0, 3) == 0) evt_in = 8'($urandom);
            tx_pop  = ($urandom_range(0, 2) == 0);
            rx_push = ($urandom_range(0, 1) == 0);
            rx_byte = 8'($urandom);
            tick();
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule